// File: doc/BRIEF.md
# Pseudo-Random Byte and CRC16 Engine

A single 16-bit linear feedback shift register sits behind a small register bus. It does two jobs. It hands out pseudo-random bytes to a processor, and it accumulates a CRC16 checksum over bytes that the processor writes. The feedback polynomial is x^16 + x^15 + x^2 + 1, which is 0x8005 in normal (left-shifting) form. A single step works like this: the feedback bit is the incoming data bit XORed with state bit 15, the state shifts left by one, and when the feedback bit is 1 the result is XORed with 0x8005. Random stepping uses an incoming bit of 0.

The bus has three addresses:
- Address 0 is the low data byte.
- Address 1 is the high data byte.
- Address 2 is a 2-bit mode field, read back as {6'b0, mode}.

Address 3 reads as zero and ignores writes. Read data is combinational from the current address and always shows the state as it was before the coming clock edge.

Seeding is done through the low byte. Each write there moves the old low byte up into the high byte, so two writes load all 16 bits. CRC input goes through the high byte, one byte per clock. The mode field selects how reads advance the register:
- 00 advances it on low-byte reads.
- 01 advances it once and then clears itself.
- 10 does nothing.
- 11 switches the generator off.

Top module: `lfsr_crc_unit`

## Requirements
- R1: After reset the state is 0x0000 and the mode field reads 00.
- R2: A read of address 1 returns state[15:8] and a read of address 2 returns {6'b0, mode}. Neither read alters the state.
- R3: In mode 00, a read of address 0 returns state[7:0] from before the edge. At that edge the state then advances by 13 single steps with an input bit of 0.
- R4: Writing 01 to address 2 advances the state by exactly one single step on the following edge. At that same edge the mode returns to 00.
- R5: In mode 11 (off) and mode 10 (reserved), reads of address 0 leave the state unchanged. Writes to addresses 0 and 1 still take effect in these modes.
- R6: A write of byte D to address 0 makes the new state {old state[7:0], D}.
- R7: A write of byte D to address 1 folds D into the state with 8 single steps in one cycle, using D[7] first. Writes on consecutive cycles are each folded.
- R8: From seed 0xFFFF, the bytes 0x03, 0x41, 0x42, 0x43 written on consecutive cycles leave the state at 0xB4BC.
- R9: A write takes priority over any advance in the same cycle. This covers both a low-byte read in mode 00 and a pending mode-01 step, and the step that loses is dropped. A read made in that cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; an address-0 read advances the state in mode 00 |
| bus_addr_i | input | 2 | 0 = low byte, 1 = high byte, 2 = mode, 3 = unused |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, pre-edge value |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a low-byte write and a low-byte read in mode 00. The bench raises both strobes together on address 0. It expects the old low byte on the read data and a seeded state with no 13-step advance afterwards. The second pair is a pending mode-01 step and a data write. The bench writes mode 01 and follows it with a low-byte write on the very next cycle. It then expects the seeded value with no single step applied and the mode back at 00.

// File: rtl/lfsr_crc_pkg.sv
package lfsr_crc_pkg;

  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_MODE = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_ONE  = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_OFF  = 2'b11
  } rng_mode_e;

endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/lfsr_step_net.sv
// Unrolled chain of single LFSR steps; data_i[STEPS-1] is consumed first.
module lfsr_step_net #(
  parameter int          WIDTH = 16,
  parameter int          STEPS = 8,
  parameter logic [15:0] POLY  = 16'h8005
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [STEPS-1:0] data_i,
  output logic [WIDTH-1:0] state_o
);

  localparam logic [WIDTH-1:0] POLY_W = WIDTH'(POLY);

  logic [WIDTH-1:0] chain [0:STEPS];
  logic [STEPS-1:0] fb;

  assign chain[0] = state_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign fb[g] = data_i[STEPS-1-g] ^ chain[g][WIDTH-1];
    assign chain[g+1] = {chain[g][WIDTH-2:0], 1'b0} ^ (fb[g] ? POLY_W : '0);
  end

  assign state_o = chain[STEPS];

endmodule

// File: rtl/lfsr_mode_reg.sv
module lfsr_mode_reg
  import lfsr_crc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic [1:0] wdata_i,
  output rng_mode_e mode_o,
  output logic      step_once_o
);

  rng_mode_e mode_q, mode_d;
  logic      mode_en;

  always_comb begin
    mode_d  = mode_q;
    mode_en = 1'b0;
    if (wr_en_i) begin
      mode_d  = rng_mode_e'(wdata_i);
      mode_en = 1'b1;
    end else if (mode_q == MODE_ONE) begin
      mode_d  = MODE_RUN;
      mode_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_RUN;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o      = mode_q;
  assign step_once_o = (mode_q == MODE_ONE);

  // R4: single-step mode lasts one cycle unless rewritten
  p_auto_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ONE && !wr_en_i) |=> (mode_q == MODE_RUN));

  // R1/R4: a written value is held until the next write or auto-clear
  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && mode_q != MODE_ONE) |=> $stable(mode_q));

endmodule

// File: rtl/lfsr_crc_unit.sv
module lfsr_crc_unit
  import lfsr_crc_pkg::*;
#(
  parameter int          BYTE_W     = 8,
  parameter int          RAND_STEPS = 13,
  parameter logic [15:0] POLY       = 16'h8005
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o
);

  localparam int W = 2 * BYTE_W;

  logic      rst_sync_n;
  reg_addr_e addr;
  rng_mode_e mode;
  logic      step_once;
  logic      mode_wr;

  logic [W-1:0] state_q, state_d;
  logic         state_en;
  logic [W-1:0] crc_next, rand_next, one_next;

  lfsr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  assign addr    = reg_addr_e'(bus_addr_i);
  assign mode_wr = bus_wr_i && (addr == ADDR_MODE);

  lfsr_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_en_i    (mode_wr),
    .wdata_i    (bus_wdata_i[1:0]),
    .mode_o     (mode),
    .step_once_o(step_once)
  );

  lfsr_step_net #(.WIDTH(W), .STEPS(BYTE_W), .POLY(POLY)) u_crc (
    .state_i(state_q),
    .data_i (bus_wdata_i),
    .state_o(crc_next)
  );

  lfsr_step_net #(.WIDTH(W), .STEPS(RAND_STEPS), .POLY(POLY)) u_rand (
    .state_i(state_q),
    .data_i ('0),
    .state_o(rand_next)
  );

  lfsr_step_net #(.WIDTH(W), .STEPS(1), .POLY(POLY)) u_one (
    .state_i(state_q),
    .data_i (1'b0),
    .state_o(one_next)
  );

  // Next-state selection: writes win over every kind of advance
  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    if (bus_wr_i && addr == ADDR_LO) begin
      state_d  = {state_q[BYTE_W-1:0], bus_wdata_i};
      state_en = 1'b1;
    end else if (bus_wr_i && addr == ADDR_HI) begin
      state_d  = crc_next;
      state_en = 1'b1;
    end else if (!bus_wr_i && step_once) begin
      state_d  = one_next;
      state_en = 1'b1;
    end else if (!bus_wr_i && bus_rd_i && addr == ADDR_LO && mode == MODE_RUN) begin
      state_d  = rand_next;
      state_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)   state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  always_comb begin
    unique case (addr)
      ADDR_LO:   bus_rdata_o = state_q[BYTE_W-1:0];
      ADDR_HI:   bus_rdata_o = state_q[W-1:BYTE_W];
      ADDR_MODE: bus_rdata_o = {{(BYTE_W-2){1'b0}}, mode};
      default:   bus_rdata_o = '0;
    endcase
  end

  // R6: low-byte write shifts the old low byte up
  p_seed_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_wr_i && addr == ADDR_LO) |=>
      (state_q[W-1:BYTE_W] == $past(state_q[BYTE_W-1:0])) &&
      (state_q[BYTE_W-1:0] == $past(bus_wdata_i)));

  // R2: reads of the high byte or mode never move the state
  p_hi_read_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_rd_i && !bus_wr_i && addr != ADDR_LO && !step_once) |=> $stable(state_q));

  // R5: generator off or reserved holds the state without writes
  p_off_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((mode == MODE_OFF || mode == MODE_RSVD) && !bus_wr_i) |=> $stable(state_q));

  // R9: a simultaneous read does not displace the write
  p_wr_priority_r9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_wr_i && bus_rd_i && addr == ADDR_LO) |=>
      (state_q[BYTE_W-1:0] == $past(bus_wdata_i)));

endmodule

// File: tb/lfsr_crc_unit_tb.sv
module lfsr_crc_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int nvec = 0;
  int nfail = 0;
  logic [15:0] exp_s = 16'h0000;
  logic [1:0]  exp_m = 2'b00;

  always #2.5 clk = ~clk;

  lfsr_crc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  function automatic logic [15:0] m_step(logic [15:0] s, logic din);
    logic fb;
    logic [15:0] r;
    fb = din ^ s[15];
    r  = s << 1;
    if (fb) r = r ^ 16'h8005;
    return r;
  endfunction

  function automatic logic [15:0] m_byte(logic [15:0] s, logic [7:0] b);
    logic [15:0] r = s;
    for (int i = 7; i >= 0; i--) r = m_step(r, b[i]);
    return r;
  endfunction

  function automatic logic [15:0] m_rand(logic [15:0] s);
    logic [15:0] r = s;
    for (int i = 0; i < 13; i++) r = m_step(r, 1'b0);
    return r;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] expv);
    nvec++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic do_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 2'd3;
    case (a)
      2'd0: exp_s = {exp_s[7:0], d};
      2'd1: exp_s = m_byte(exp_s, d);
      2'd2: begin
        exp_m = d[1:0];
        if (exp_m == 2'b01) begin
          exp_s = m_step(exp_s, 1'b0);
          exp_m = 2'b00;
        end
      end
      default: ;
    endcase
  endtask

  task automatic do_rd(logic [1:0] a, string tag);
    logic [7:0] e;
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1;
    e = (a == 2'd0) ? exp_s[7:0] : (a == 2'd1) ? exp_s[15:8] :
        (a == 2'd2) ? {6'b0, exp_m} : 8'h00;
    chk(tag, {8'h00, rdata}, {8'h00, e});
    @(negedge clk);
    rd = 1'b0; addr = 2'd3;
    if (a == 2'd0 && exp_m == 2'b00) exp_s = m_rand(exp_s);
  endtask

  // reads the whole state without advancing it: switches off, reads, restores mode
  task automatic peek(string tag);
    logic [1:0] keep = exp_m;
    do_wr(2'd2, 8'h03);
    do_rd(2'd1, tag);
    do_rd(2'd0, tag);
    do_rd(2'd0, tag);
    if (keep != 2'b01) do_wr(2'd2, {6'b0, keep});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin : main
    logic [15:0] pre;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    do_rd(2'd1, "R1 hi");
    do_rd(2'd2, "R1 mode");
    do_rd(2'd0, "R1 lo");
    do_rd(2'd1, "R2 zero stays zero");

    // R6 and R5 (mode 11): seeding sweep
    do_wr(2'd2, 8'h03);
    for (int v = 0; v < 256; v++) begin
      do_wr(2'd0, 8'(v));
      do_rd(2'd1, "R6 hi after seed");
      do_rd(2'd0, "R5 off lo");
      do_rd(2'd0, "R5 off lo repeat");
    end

    // R7 CRC fold sweep, R2 read of mode
    for (int v = 0; v < 256; v++) begin
      do_wr(2'd0, 8'(v));
      do_wr(2'd0, ~8'(v));
      do_wr(2'd1, 8'(v * 37 + 5));
      do_rd(2'd1, "R7 hi");
      do_rd(2'd0, "R7 lo");
      do_rd(2'd2, "R2 mode off");
    end

    // R3 random reads in mode 00
    do_wr(2'd2, 8'h00);
    for (int v = 0; v < 256; v++) begin
      do_wr(2'd0, 8'(v));
      do_wr(2'd0, 8'(v) ^ 8'h5A);
      do_rd(2'd0, "R3 lo first");
      do_rd(2'd1, "R3 hi no advance");
      do_rd(2'd0, "R3 lo second");
      do_rd(2'd0, "R3 lo third");
    end

    // R4 single step and self-clear
    for (int v = 0; v < 64; v++) begin
      do_wr(2'd0, 8'(v * 3));
      do_wr(2'd0, 8'(v * 11 + 1));
      pre = exp_s;
      do_wr(2'd2, 8'h01);
      do_rd(2'd2, "R4 mode cleared");
      chk("R4 model one step", exp_s, m_step(pre, 1'b0));
      do_rd(2'd1, "R4 hi");
      do_rd(2'd0, "R4 lo");
    end

    // R5 reserved mode
    do_wr(2'd2, 8'h02);
    do_wr(2'd0, 8'h9C);
    do_rd(2'd0, "R5 rsvd lo");
    do_rd(2'd0, "R5 rsvd lo repeat");
    do_rd(2'd1, "R5 rsvd hi");

    // R8 known CRC, bytes on consecutive cycles
    do_wr(2'd2, 8'h03);
    do_wr(2'd0, 8'hFF);
    do_wr(2'd0, 8'hFF);
    @(negedge clk);
    wr = 1'b1; addr = 2'd1; wdata = 8'h03;
    @(negedge clk); wdata = 8'h41;
    @(negedge clk); wdata = 8'h42;
    @(negedge clk); wdata = 8'h43;
    @(negedge clk); wr = 1'b0; addr = 2'd3;
    exp_s = 16'hB4BC;
    do_rd(2'd1, "R8 crc hi");
    do_rd(2'd0, "R8 crc lo");

    // R9 write and read together on the low byte in mode 00
    do_wr(2'd2, 8'h00);
    do_wr(2'd0, 8'h12);
    do_wr(2'd0, 8'h34);
    @(negedge clk);
    wr = 1'b1; rd = 1'b1; addr = 2'd0; wdata = 8'hC7;
    #1;
    chk("R9 read returns pre-write", {8'h00, rdata}, 16'h0034);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; addr = 2'd3;
    exp_s = 16'h34C7;
    peek("R9 no advance on collision");

    // R9 pending single step loses to a data write
    do_wr(2'd0, 8'h55);
    @(negedge clk);
    wr = 1'b1; addr = 2'd2; wdata = 8'h01;
    @(negedge clk);
    addr = 2'd0; wdata = 8'hAB;
    @(negedge clk);
    wr = 1'b0; addr = 2'd3;
    exp_s = {exp_s[7:0], 8'hAB};
    exp_m = 2'b00;
    do_rd(2'd2, "R9 mode cleared after lost step");
    peek("R9 step dropped");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule